// File: doc/BRIEF.md
# Nonvolatile memory timing clock divider

This block produces the slow timing reference that paces program and erase operations of a nonvolatile memory from the system bus clock. Software writes one configuration byte. That byte selects an optional fixed prescale of 8 and a 6-bit divide value. The resulting rate is (bus / prescale) / (DIV + 1). Software picks the pair so that the derived clock falls between 150 kHz and 200 kHz.

The derived clock is delivered as a one-bus-cycle enable tick. It comes from free-running counters that reload at terminal count, so no clock is gated.

The configuration byte can be written only once after reset. Until that write happens, no ticks are produced, and any program/erase start request is rejected with an access error.

A pulse timer forms the program/erase timing pulse. On an accepted start request it waits for the next derived tick. It then holds the pulse high for a whole number of derived periods (one by default), which gives a pulse of 5 to 6.7 µs for a valid setting.

Top module: `nvm_clkdiv`

## Requirements
- R1: After reset, rd_data_o is 0x00, and div_set_o, tick_o, pe_pulse_o, pe_busy_o, pe_done_o and acc_err_o are all low.
- R2: After the first write, rd_data_o reads back as follows: bit 7 = 1 (written), bit 6 = prescale enable, and bits 5:0 = divide value. div_set_o is high.
- R3: Once the register has been written, any further write leaves rd_data_o and the tick period unchanged until the next reset.
- R4: With prescale enable p and divide value d, tick_o pulses once every (p ? 8 : 1) * (d + 1) bus cycles. Each pulse is high for one cycle whenever that period exceeds 1.
- R5: Before the register has been written, tick_o stays low.
- R6: A start request on pe_start_i before the register has been written raises acc_err_o for exactly one cycle, in the cycle after the request, and starts no pulse.
- R7: An accepted start produces a pe_pulse_o that rises in the cycle after a tick and stays high for exactly PULSE_TICKS tick periods. At the default of 1, the pulse lasts 5 to 6.7 µs for every valid setting.
- R8: pe_done_o is high for one cycle, at the cycle where pe_pulse_o falls. pe_busy_o is high from acceptance until then. A start request made while busy is ignored.
- R9: With prescale off and divide value 0, the bus clock passes through: tick_o is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data: bit 6 prescale enable, bits 5:0 divide value |
| rd_data_o | output | 8 | Register read value: bit 7 written flag, bit 6 prescale, bits 5:0 divide |
| div_set_o | output | 1 | Divider has been written since reset |
| tick_o | output | 1 | One-cycle enable at the derived rate |
| pe_start_i | input | 1 | Program/erase pulse start request |
| pe_pulse_o | output | 1 | Program/erase timing pulse |
| pe_busy_o | output | 1 | Pulse timer armed or running |
| pe_done_o | output | 1 | One-cycle strobe when the pulse ends |
| acc_err_o | output | 1 | One-cycle access error for a start before the divider is set |

## Verification
The divider is exercised with eight settings, covering bus clocks from 20 MHz down to 150 kHz. One setting uses the prescale and divide together (period 104), five use the divide alone (periods 50 down to 5), and two use full pass-through (period 1). Together these show apart a missing or misplaced prescale, an off-by-one in the reload compare, and a tick that stays high too long. For each setting, the pulse width is compared with the measured period, and its length in time is checked against the 5 to 6.7 µs window. Directed cases then show that a second write and a start made while busy are both ignored, and that a start before configuration gives only an error strobe.

// File: rtl/nvm_clkdiv_pkg.sv
`timescale 1ns/1ps
package nvm_clkdiv_pkg;
  localparam int unsigned DIV_W   = 6;
  localparam int unsigned PRE_DIV = 8;
  localparam int unsigned REG_W   = DIV_W + 2;

  typedef struct packed {
    logic             pre_en;
    logic [DIV_W-1:0] div;
  } cfg_t;

  typedef enum logic [1:0] {PT_IDLE, PT_ARM, PT_BUSY} pt_state_e;
endpackage

// File: rtl/nvm_clkdiv_cfg.sv
`timescale 1ns/1ps
module nvm_clkdiv_cfg
  import nvm_clkdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output cfg_t             cfg_o,
  output logic             set_o,
  output logic             load_o
);
  cfg_t cfg_q;
  logic set_q;

  assign load_o = wr_en_i && !set_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      set_q <= 1'b0;
    end else if (load_o) begin
      cfg_q <= cfg_t'(wr_data_i[REG_W-2:0]);
      set_q <= 1'b1;
    end
  end

  assign cfg_o = cfg_q;
  assign set_o = set_q;
endmodule

// File: rtl/nvm_clkdiv_tickgen.sv
`timescale 1ns/1ps
module nvm_clkdiv_tickgen
  import nvm_clkdiv_pkg::*;
#(
  parameter int unsigned PRE = PRE_DIV
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  cfg_t cfg_i,
  output logic tick_o
);
  localparam int unsigned PRE_W = (PRE > 1) ? $clog2(PRE) : 1;

  logic             pre_hit;
  logic [DIV_W-1:0] div_cnt;
  logic             div_hit;
  logic             tick_q;
  logic             run;

  assign run = en_i && !clr_i;

  generate
    if (PRE > 1) begin : g_pre
      logic [PRE_W-1:0] pre_cnt;
      logic             pre_last;
      assign pre_last = (pre_cnt == PRE_W'(PRE - 1));
      assign pre_hit  = !cfg_i.pre_en || pre_last;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                    pre_cnt <= '0;
        else if (!run || !cfg_i.pre_en) pre_cnt <= '0;
        else if (pre_last)              pre_cnt <= '0;
        else                            pre_cnt <= pre_cnt + 1'b1;
      end
    end else begin : g_nopre
      assign pre_hit = 1'b1;
    end
  endgenerate

  assign div_hit = (div_cnt == cfg_i.div);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else if (!run) begin
      div_cnt <= '0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= pre_hit && div_hit;
      if (pre_hit) div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
    end
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/nvm_clkdiv_pulse.sv
`timescale 1ns/1ps
module nvm_clkdiv_pulse
  import nvm_clkdiv_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic set_i,
  input  logic start_i,
  output logic pulse_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  localparam int unsigned CNT_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;

  pt_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PT_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= start_i && !set_i;
      unique case (state_q)
        PT_IDLE: if (start_i && set_i) state_q <= PT_ARM;
        PT_ARM: if (tick_i) begin
          state_q <= PT_BUSY;
          cnt_q   <= '0;
        end
        PT_BUSY: if (tick_i) begin
          if (cnt_q == CNT_W'(PULSE_TICKS - 1)) begin
            state_q <= PT_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= PT_IDLE;
      endcase
    end
  end

  assign pulse_o = (state_q == PT_BUSY);
  assign busy_o  = (state_q != PT_IDLE);
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/nvm_clkdiv.sv
`timescale 1ns/1ps
module nvm_clkdiv
  import nvm_clkdiv_pkg::*;
#(
  parameter int unsigned PULSE_TICKS = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             div_set_o,
  output logic             tick_o,
  input  logic             pe_start_i,
  output logic             pe_pulse_o,
  output logic             pe_busy_o,
  output logic             pe_done_o,
  output logic             acc_err_o
);
  cfg_t cfg;
  logic set;
  logic load;

  nvm_clkdiv_cfg u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .set_o     (set),
    .load_o    (load)
  );

  nvm_clkdiv_tickgen #(.PRE(PRE_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (set),
    .clr_i  (load),
    .cfg_i  (cfg),
    .tick_o (tick_o)
  );

  nvm_clkdiv_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_o),
    .set_i   (set),
    .start_i (pe_start_i),
    .pulse_o (pe_pulse_o),
    .busy_o  (pe_busy_o),
    .done_o  (pe_done_o),
    .err_o   (acc_err_o)
  );

  assign rd_data_o = {set, cfg};
  assign div_set_o = set;
endmodule

// File: rtl/nvm_clkdiv_chk.sv
`timescale 1ns/1ps
module nvm_clkdiv_chk
  import nvm_clkdiv_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             div_set_o,
  input logic             tick_o,
  input logic             pe_start_i,
  input logic             pe_pulse_o,
  input logic             pe_busy_o,
  input logic             pe_done_o,
  input logic             acc_err_o
);
  // R5
  no_tick_unset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !div_set_o |-> !tick_o);

  // R3
  write_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_set_o && wr_en_i) |=> $stable(rd_data_o));

  // R2
  set_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_set_o) |-> $past(wr_en_i));

  // R6
  err_on_early_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_start_i && !div_set_o) |=> (acc_err_o && !pe_busy_o));

  // R7
  pulse_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pe_pulse_o) |-> $past(tick_o));

  // R8
  done_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_done_o |-> (!pe_pulse_o && !pe_busy_o && $past(pe_pulse_o)));
endmodule

bind nvm_clkdiv nvm_clkdiv_chk chk_i (.*);

// File: tb/nvm_clkdiv_tb_top.sv
`timescale 1ns/1ps
module nvm_clkdiv_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       pe_start = 1'b0;
  logic [7:0] rd_data;
  logic       div_set, tick, pe_pulse, pe_busy, pe_done, acc_err;

  int checks = 0;
  int errors = 0;

  localparam int NV = 8;
  localparam logic [7:0] CFG_TAB [NV] = '{8'h4C, 8'h31, 8'h27, 8'h13, 8'h09, 8'h04, 8'h00, 8'h00};
  localparam int PER_TAB [NV] = '{104, 50, 40, 20, 10, 5, 1, 1};
  localparam int KHZ_TAB [NV] = '{20000, 10000, 8000, 4000, 2000, 1000, 200, 150};

  always #2.5 clk = ~clk;

  nvm_clkdiv dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .div_set_o  (div_set),
    .tick_o     (tick),
    .pe_start_i (pe_start),
    .pe_pulse_o (pe_pulse),
    .pe_busy_o  (pe_busy),
    .pe_done_o  (pe_done),
    .acc_err_o  (acc_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; pe_start = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic write_cfg(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic measure_period(output int per);
    int t = 0;
    while (!tick && t < 1000) begin cyc(1); t++; end
    per = 0;
    do begin cyc(1); per++; end while (!tick && per < 1000);
  endtask

  task automatic measure_pulse(input int again, output int width, output int dones);
    width = 0; dones = 0;
    pe_start = 1'b1;
    cyc(1);
    pe_start = 1'b0;
    for (int t = 0; t < 3000; t++) begin
      if (pe_pulse) width++;
      if (pe_done) dones++;
      if (width > 0 && !pe_pulse) break;
      pe_start = (t == again);
      cyc(1);
    end
    pe_start = 1'b0;
  endtask

  initial begin
    cyc(150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int per, w, d, highs, ns;
    do_reset();
    // R1 reset state
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 div_set", int'(div_set), 0);
    chk("R1 tick", int'(tick), 0);
    chk("R1 pulse", int'(pe_pulse), 0);
    chk("R1 busy", int'(pe_busy), 0);
    chk("R1 err", int'(acc_err), 0);
    // R5 no tick before write
    highs = 0;
    for (int i = 0; i < 20; i++) begin if (tick) highs++; cyc(1); end
    chk("R5 ticks before write", highs, 0);
    // R6 early start
    pe_start = 1'b1; cyc(1); pe_start = 1'b0;
    chk("R6 acc_err", int'(acc_err), 1);
    chk("R6 busy", int'(pe_busy), 0);
    cyc(1);
    chk("R6 acc_err single", int'(acc_err), 0);
    chk("R6 no pulse", int'(pe_pulse), 0);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      write_cfg(CFG_TAB[v]);
      chk("R2 readback", int'(rd_data), int'({1'b1, CFG_TAB[v][6:0]}));
      chk("R2 div_set", int'(div_set), 1);
      measure_period(per);
      chk((PER_TAB[v] == 1) ? "R9 period" : "R4 period", per, PER_TAB[v]);
      measure_pulse(-1, w, d);
      chk("R7 pulse width", w, PER_TAB[v]);
      ns = w * 1000000 / KHZ_TAB[v];
      chk("R7 pulse in 5..6.7us", int'(ns >= 5000 && ns <= 6700), 1);
      chk("R8 done count", d, 1);
      chk("R8 busy after done", int'(pe_busy), 0);
    end

    // R3 second write ignored
    do_reset();
    write_cfg(8'h4C);
    cyc(2);
    write_cfg(8'h00);
    cyc(1);
    chk("R3 readback", int'(rd_data), 8'hCC);
    measure_period(per);
    chk("R3 period", per, 104);

    // R8 start while busy ignored
    measure_pulse(10, w, d);
    chk("R8 width with restart", w, 104);
    chk("R8 single done", d, 1);
    cyc(3);
    chk("R8 restart ignored", int'(pe_busy), 0);

    // R9 pass-through
    do_reset();
    write_cfg(8'h00);
    cyc(1);
    highs = 0;
    for (int i = 0; i < 8; i++) begin if (tick) highs++; cyc(1); end
    chk("R9 tick every cycle", highs, 8);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule